// File: doc/BRIEF.md
# CRC-6 Multiframe Error Checker

This block watches a serial extended-superframe T1 bit stream and counts multiframes whose CRC-6 check bits are wrong. It divides every bit of a 24-frame, 4632-bit multiframe by a six-bit generator polynomial. It keeps the remainder until the next multiframe, then compares that stored remainder with the six check bits carried in the following multiframe. Each multiframe that has at least one differing check bit adds one to a 16-bit error count.

The block does not search for alignment. A separate framer supplies per-bit markers with every valid bit: framing bit, multiframe start and check-bit slot. It can also pulse a resynchronisation input when it loses alignment. A host enables checking and states whether the current multiframe format carries CRC bits. The host reads the count directly and zeroes it with a one-cycle clear strobe.

Top module: `crc6_mf_checker`

## Requirements
- R1: The computed check bits are the remainder of a most-significant-first long division by x^6 + x + 1, with the register preset to zero at the multiframe-start bit. Every bit with `fbit_mark` or `mf_mark` set enters the division as a one, whatever its value. All other valid bits enter as received.
- R2: Check bits are the valid bits marked with `cb_mark`, one per frame in frames 2, 6, 10, 14, 18 and 22, counted from frame 1 at the multiframe start. In order of arrival they are compared with remainder bits 5, 4, 3, 2, 1 and 0 of the previous multiframe.
- R3: A multiframe whose check bits differ in one bit or in all six adds exactly one to `err_cnt`. The new value appears in the cycle after the valid multiframe-start bit that closes that multiframe. The count changes at no other time, except through a clear.
- R4: `err_cnt` is 16 bits wide and holds at all ones instead of wrapping.
- R5: A `cnt_clr` pulse makes `err_cnt` zero in the next cycle, even when an increment falls due in the same cycle.
- R6: While `chk_en` is low or `fmt_has_crc` is low, the count does not change except through a clear, and the alignment state is discarded.
- R7: After checking is enabled, or after a `resync` pulse, the check bits inside the first complete multiframe are not compared. The earliest comparison uses the check bits of the second multiframe.
- R8: Cycles with `bit_vld` low have no effect: data and markers present in those cycles are ignored.
- R9: Reset (`rst_n` low) sets `err_cnt` to zero and discards all alignment state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_en | input | 1 | Host enable for checking |
| fmt_has_crc | input | 1 | Selected multiframe format carries CRC bits |
| resync | input | 1 | Framer pulse: alignment lost, restart |
| bit_vld | input | 1 | Qualifies the data bit and markers in this cycle |
| bit_dat | input | 1 | Received serial data bit |
| fbit_mark | input | 1 | This bit is a framing bit (start of a frame) |
| mf_mark | input | 1 | This bit is the first bit of a multiframe |
| cb_mark | input | 1 | This framing bit carries a CRC check bit |
| cnt_clr | input | 1 | Clear strobe for the error count |
| err_cnt | output | 16 | Multiframe CRC error count |

## Verification
The bound assertions check the count's behaviour on every cycle. Outside a clear, the count moves by at most one, and only on a valid multiframe-start bit. It stays frozen while checking is off, never wraps from all ones, and reads zero after a clear or a reset. Three behaviours need the bench's scenarios, because they depend on a whole multiframe of history: the division result, the ordering of the check bits, and suppression of the first multiframe after enable or resync. The bench generates multiframes with random payload and random framing-bit values, injects chosen check-bit corruptions, and predicts each count. A second instance with a two-bit count shows saturation.

// File: rtl/crc6_pkg.sv
// Package: shared constants and types for the CRC-6 multiframe checker.
// Assumes one CRC bit per multiframe check slot, six slots per multiframe.
package crc6_pkg;

    localparam int          CRC6_W    = 6;
    localparam logic [5:0]  CRC6_POLY = 6'b000011;  // x^6 + x + 1, x^6 implicit
    localparam int          ERR_CNT_W = 16;

    // One received bit with its framer markers.
    typedef struct packed {
        logic vld;
        logic dat;
        logic fbit;
        logic mfs;
        logic cbp;
    } rx_beat_t;

    // Alignment state of the checker.
    typedef enum logic [1:0] {
        SYNC_IDLE  = 2'd0,  // no multiframe start seen
        SYNC_FIRST = 2'd1,  // computing first multiframe, no reference
        SYNC_ARMED = 2'd2   // reference exists for the running multiframe
    } sync_st_t;

endpackage

// File: rtl/crc6_track.sv
// Module: crc6_track
// Tracks how many multiframe starts have been seen since enable or resync.
// It decides when a remainder may be stored as a reference and when the
// finished multiframe's check bits count towards the error counter.
// Assumes mf_take is a single-cycle qualified multiframe-start strobe.
module crc6_track
    import crc6_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic resync,
    input  logic mf_take,
    output logic load_ref,
    output logic cmp_ok
);

    sync_st_t st_q;

    // Store a reference only once a full multiframe has been divided.
    assign load_ref = mf_take && active && !resync && (st_q != SYNC_IDLE);
    // Count a closing multiframe only if it was compared against a reference.
    assign cmp_ok   = mf_take && active && !resync && (st_q == SYNC_ARMED);

    // Alignment state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SYNC_IDLE;
        end else if (!active) begin
            st_q <= SYNC_IDLE;
        end else if (resync) begin
            st_q <= mf_take ? SYNC_FIRST : SYNC_IDLE;
        end else if (mf_take) begin
            case (st_q)
                SYNC_IDLE:  st_q <= SYNC_FIRST;
                SYNC_FIRST: st_q <= SYNC_ARMED;
                default:    st_q <= SYNC_ARMED;
            endcase
        end
    end

endmodule

// File: rtl/crc6_lfsr.sv
// Module: crc6_lfsr
// Serial most-significant-first polynomial divider. The register is preset
// to zero on the bit that carries preset, and that bit is divided in.
// Assumes POLY holds the generator without its top term.
module crc6_lfsr #(
    parameter int             W    = 6,
    parameter logic [W-1:0]   POLY = 6'b000011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         preset,
    input  logic         din,
    output logic [W-1:0] crc_q
);

    logic [W-1:0] base;
    logic [W-1:0] nxt;
    logic         fb;

    assign base = preset ? '0 : crc_q;
    assign fb   = base[W-1] ^ din;

    // One division step: shift left, fold the feedback into the tap bits.
    for (genvar i = 0; i < W; i++) begin : g_tap
        if (i == 0) begin : g_lsb
            assign nxt[i] = POLY[i] & fb;
        end else begin : g_mid
            assign nxt[i] = base[i-1] ^ (POLY[i] & fb);
        end
    end

    // Divider register advances on each valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (step) begin
            crc_q <= nxt;
        end
    end

endmodule

// File: rtl/crc6_cmp.sv
// Module: crc6_cmp
// Holds the remainder of the last complete multiframe and compares it, bit
// 5 first, with the check bits arriving in the current multiframe.
// Raises inc_req on the closing start bit when any slot mismatched.
// Assumes W check slots per multiframe and none on the start bit itself.
module crc6_cmp #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mf_take,
    input  logic         load_ref,
    input  logic         cmp_ok,
    input  logic         restart,
    input  logic         cb_take,
    input  logic         cb_bit,
    input  logic [W-1:0] crc_now,
    output logic         inc_req
);

    localparam int               IDX_W    = $clog2(W + 1);
    localparam int               REV_N    = 2 ** IDX_W;
    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(W);

    logic [W-1:0]     ref_q;
    logic [IDX_W-1:0] idx_q;
    logic             mis_q;
    logic [REV_N-1:0] ref_rev;
    logic             exp_bit;

    // Reference reordered so the first arriving slot reads index 0.
    for (genvar i = 0; i < REV_N; i++) begin : g_rev
        if (i < W) begin : g_used
            assign ref_rev[i] = ref_q[W-1-i];
        end else begin : g_pad
            assign ref_rev[i] = 1'b0;
        end
    end

    assign exp_bit = ref_rev[idx_q];
    assign inc_req = cmp_ok && mis_q;

    // Reference capture, slot index and mismatch accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
            idx_q <= '0;
            mis_q <= 1'b0;
        end else if (mf_take) begin
            if (load_ref) begin
                ref_q <= crc_now;
            end
            idx_q <= '0;
            mis_q <= 1'b0;
        end else if (restart) begin
            idx_q <= '0;
            mis_q <= 1'b0;
        end else if (cb_take && (idx_q < IDX_LAST)) begin
            mis_q <= mis_q | (cb_bit ^ exp_bit);
            idx_q <= idx_q + IDX_ONE;
        end
    end

endmodule

// File: rtl/crc6_sat_cnt.sv
// Module: crc6_sat_cnt
// Saturating event counter with a clear that beats a same-cycle increment.
module crc6_sat_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    // Count update: clear first, then a bounded increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

endmodule

// File: rtl/crc6_mf_checker.sv
// Module: crc6_mf_checker (top)
// CRC-6 multiframe error checker for a serial extended-superframe stream.
// Divides each multiframe, with framing bits taken as ones, stores the
// remainder, compares it with the next multiframe's check bits and counts
// mismatching multiframes. Assumes framer markers are aligned to bit_dat.
module crc6_mf_checker
    import crc6_pkg::*;
#(
    parameter int                CNT_W    = ERR_CNT_W,
    parameter int                CRC_W    = CRC6_W,
    parameter logic [CRC_W-1:0]  CRC_POLY = CRC6_POLY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_en,
    input  logic             fmt_has_crc,
    input  logic             resync,
    input  logic             bit_vld,
    input  logic             bit_dat,
    input  logic             fbit_mark,
    input  logic             mf_mark,
    input  logic             cb_mark,
    input  logic             cnt_clr,
    output logic [CNT_W-1:0] err_cnt
);

    rx_beat_t         beat;
    logic             active;
    logic             restart;
    logic             mf_take;
    logic             cb_take;
    logic             div_bit;
    logic             load_ref;
    logic             cmp_ok;
    logic             inc_req;
    logic [CRC_W-1:0] crc_q;

    assign beat    = '{vld: bit_vld, dat: bit_dat, fbit: fbit_mark,
                       mfs: mf_mark, cbp: cb_mark};
    assign active  = chk_en && fmt_has_crc;
    assign restart = !active || resync;
    assign mf_take = beat.vld && beat.mfs;
    assign cb_take = beat.vld && beat.cbp && !beat.mfs;
    assign div_bit = (beat.fbit || beat.mfs) ? 1'b1 : beat.dat;

    crc6_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .resync   (resync),
        .mf_take  (mf_take),
        .load_ref (load_ref),
        .cmp_ok   (cmp_ok)
    );

    crc6_lfsr #(
        .W    (CRC_W),
        .POLY (CRC_POLY)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (beat.vld),
        .preset (mf_take),
        .din    (div_bit),
        .crc_q  (crc_q)
    );

    crc6_cmp #(
        .W (CRC_W)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .mf_take  (mf_take),
        .load_ref (load_ref),
        .cmp_ok   (cmp_ok),
        .restart  (restart),
        .cb_take  (cb_take),
        .cb_bit   (beat.dat),
        .crc_now  (crc_q),
        .inc_req  (inc_req)
    );

    crc6_sat_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (inc_req),
        .cnt_q (err_cnt)
    );

endmodule

// File: rtl/crc6_mf_checker_chk.sv
// Module: crc6_mf_checker_chk
// Port-level properties of the error count, bound to every checker instance.
module crc6_mf_checker_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chk_en,
    input logic             fmt_has_crc,
    input logic             bit_vld,
    input logic             mf_mark,
    input logic             cnt_clr,
    input logic [CNT_W-1:0] err_cnt
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    p_reset_zero_r9: assert property (@(posedge clk)
        !rst_n |=> err_cnt == '0);

    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> (err_cnt == $past(err_cnt)) || (err_cnt == $past(err_cnt) + CNT_ONE));

    p_only_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bit_vld && mf_mark) && !cnt_clr) |=> $stable(err_cnt));

    p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == '1 && !cnt_clr) |=> err_cnt == '1);

    p_clr_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> err_cnt == '0);

    p_frozen_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(chk_en && fmt_has_crc) && !cnt_clr) |=> $stable(err_cnt));

endmodule

bind crc6_mf_checker crc6_mf_checker_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chk_en      (chk_en),
    .fmt_has_crc (fmt_has_crc),
    .bit_vld     (bit_vld),
    .mf_mark     (mf_mark),
    .cnt_clr     (cnt_clr),
    .err_cnt     (err_cnt)
);

// File: tb/crc6_mf_checker_tb_top.sv
// Bench: random multiframes with chosen check-bit corruptions, a predicted
// count per multiframe start, plus directed enable, resync, clear and gap cases.
module crc6_mf_checker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int FRAMES     = 24;
    localparam int FRAME_BITS = 193;
    localparam int SAT_W      = 2;
    localparam int SAT_MAX    = 3;
    localparam int WD_CYCLES  = 200000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              chk_en = 1'b0;
    logic              fmt_has_crc = 1'b0;
    logic              resync = 1'b0;
    logic              bit_vld = 1'b0;
    logic              bit_dat = 1'b0;
    logic              fbit_mark = 1'b0;
    logic              mf_mark = 1'b0;
    logic              cb_mark = 1'b0;
    logic              cnt_clr = 1'b0;
    logic [15:0]       err_cnt;
    logic [SAT_W-1:0]  sat_cnt;

    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    int          exp_cnt = 0;
    int          exp_sat = 0;
    int          m_state = 0;
    bit          m_pend = 1'b0;
    bit          act = 1'b0;
    logic [5:0]  m_ref = '0;
    logic [5:0]  m_last = '0;
    int unsigned seed_dummy;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc6_mf_checker dut_i (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .fmt_has_crc(fmt_has_crc),
        .resync(resync), .bit_vld(bit_vld), .bit_dat(bit_dat),
        .fbit_mark(fbit_mark), .mf_mark(mf_mark), .cb_mark(cb_mark),
        .cnt_clr(cnt_clr), .err_cnt(err_cnt)
    );

    crc6_mf_checker #(.CNT_W(SAT_W)) dut_sat_i (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .fmt_has_crc(fmt_has_crc),
        .resync(resync), .bit_vld(bit_vld), .bit_dat(bit_dat),
        .fbit_mark(fbit_mark), .mf_mark(mf_mark), .cb_mark(cb_mark),
        .cnt_clr(cnt_clr), .err_cnt(sat_cnt)
    );

    // One long-division step by x^6 + x + 1, most significant bit first (R1).
    function automatic logic [5:0] crc_step(input logic [5:0] c, input logic d);
        logic fb;
        fb = c[5] ^ d;
        return {c[4:0], 1'b0} ^ (fb ? 6'b000011 : 6'b000000);
    endfunction

    task automatic check_counts(input string tag);
        n_vec++;
        if (err_cnt !== 16'(exp_cnt)) begin
            n_bad++;
            $display("FAIL %s: err_cnt=%0d expected %0d", tag, err_cnt, exp_cnt);
        end
        n_vec++;
        if (sat_cnt !== SAT_W'(exp_sat)) begin
            n_bad++;
            $display("FAIL %s (R4 saturation): sat_cnt=%0d expected %0d", tag, sat_cnt, exp_sat);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic junk_cycle();
        @(negedge clk);
        bit_vld   = 1'b0;
        bit_dat   = 1'($urandom);
        fbit_mark = 1'($urandom);
        mf_mark   = 1'($urandom);
        cb_mark   = 1'($urandom);
        cnt_clr   = 1'b0;
        resync    = 1'b0;
        @(posedge clk);
    endtask

    // Drives one valid bit, sometimes preceded by an invalid junk cycle (R8).
    task automatic drive_bit(input logic d, input logic fb, input logic mfs,
                             input logic cbp, input logic clr);
        if ($urandom_range(15) == 0) junk_cycle();
        @(negedge clk);
        bit_vld   = 1'b1;
        bit_dat   = d;
        fbit_mark = fb;
        mf_mark   = mfs;
        cb_mark   = cbp;
        cnt_clr   = clr;
        resync    = 1'b0;
        @(posedge clk);
    endtask

    task automatic model_bump();
        if (exp_cnt < 65535) exp_cnt++;
        if (exp_sat < SAT_MAX) exp_sat++;
    endtask

    // Sends a whole multiframe whose check bits are the previous remainder
    // XOR mask; the count is checked right after its start bit.
    task automatic send_mf(input logic [5:0] mask, input bit clr, input string tag);
        logic [5:0] crc;
        bit         cmp_live;
        crc = '0;
        if (!act) begin
            m_state = 0;
            m_pend  = 1'b0;
        end else begin
            if (m_state == 2 && m_pend) model_bump();
            if (m_state >= 1) m_ref = m_last;
            if (m_state < 2) m_state++;
        end
        if (clr) begin
            exp_cnt = 0;
            exp_sat = 0;
        end
        cmp_live = act && (m_state == 2);
        for (int f = 0; f < FRAMES; f++) begin
            for (int b = 0; b < FRAME_BITS; b++) begin
                logic d, fb, mfs, cbp;
                int k;
                fb  = (b == 0);
                mfs = fb && (f == 0);
                cbp = fb && ((f % 4) == 1);
                k   = f / 4;
                if (cbp && cmp_live) d = m_ref[5-k] ^ mask[5-k];
                else                 d = 1'($urandom);
                crc = mfs ? crc_step(6'b0, 1'b1) : crc_step(crc, fb ? 1'b1 : d);
                drive_bit(d, fb, mfs, cbp, mfs ? clr : 1'b0);
                if (mfs) begin
                    #1;
                    check_counts(tag);
                end
            end
        end
        m_last = crc;
        m_pend = cmp_live && (mask != 6'b0);
    endtask

    task automatic set_mode(input logic en, input logic fmt);
        @(negedge clk);
        chk_en      = en;
        fmt_has_crc = fmt;
        bit_vld     = 1'b0;
        act         = en && fmt;
        if (!act) begin
            m_state = 0;
            m_pend  = 1'b0;
        end
        @(posedge clk);
    endtask

    task automatic pulse_resync();
        @(negedge clk);
        bit_vld = 1'b0;
        resync  = 1'b1;
        @(posedge clk);
        m_state = 0;
        m_pend  = 1'b0;
    endtask

    task automatic idle_clear();
        @(negedge clk);
        bit_vld = 1'b0;
        cnt_clr = 1'b1;
        @(posedge clk);
        #1;
        exp_cnt = 0;
        exp_sat = 0;
        check_counts("R5 idle clear");
        @(negedge clk);
        cnt_clr = 1'b0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL R3 watchdog: cycles=%0d expected completion earlier", WD_CYCLES);
        finish_run();
    end

    initial begin
        logic [5:0] mask;
        seed_dummy = $urandom(32'h00C6C6C6);
        repeat (4) @(posedge clk);
        #1;
        check_counts("R9 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        // R6: checking disabled, then format without CRC.
        set_mode(1'b0, 1'b1);
        send_mf(6'h3F, 1'b0, "R6 disabled");
        send_mf(6'h3F, 1'b0, "R6 disabled");
        set_mode(1'b1, 1'b0);
        send_mf(6'h3F, 1'b0, "R6 no-crc format");
        send_mf(6'h3F, 1'b0, "R6 no-crc format");

        // R7: first multiframe after enable carries garbage check bits.
        set_mode(1'b1, 1'b1);
        send_mf(6'h15, 1'b0, "R7 first after enable");

        // R1 R2 R3: directed and random corruptions; 7 errors saturate R4.
        for (int i = 0; i < 9; i++) begin
            case (i)
                0: mask = 6'h01;
                1: mask = 6'h20;
                2: mask = 6'h3F;
                3: mask = 6'h00;
                8: mask = 6'h00;
                default: mask = 6'($urandom_range(63, 1));
            endcase
            send_mf(mask, 1'b0, "R1 R2 R3 compare");
            if (i == 4) begin
                for (int j = 0; j < 40; j++) junk_cycle();
                #1;
                check_counts("R8 invalid cycles");
            end
        end

        idle_clear();

        // R7: resync suppresses the next multiframe's comparison.
        pulse_resync();
        send_mf(6'h3F, 1'b0, "R7 after resync");
        send_mf(6'h00, 1'b0, "R7 after resync");
        send_mf(6'h2A, 1'b0, "R3 after resync");
        send_mf(6'h00, 1'b0, "R3 after resync");

        // R5: clear on the same start bit that closes an errored multiframe.
        send_mf(6'h11, 1'b0, "R3 before clear");
        send_mf(6'h00, 1'b1, "R5 clear beats increment");
        send_mf(6'h00, 1'b0, "R5 after clear");

        finish_run();
    end

endmodule